// File: doc/BRIEF.md
# Associative Word Store with Priority Search

This block is a small content-addressable memory of 32 words, each 32 bits wide. It has three request ports that work on their own and may all be used in the same clock cycle. The indexed write port stores a word at a chosen slot. The indexed read port returns the word held in a slot. The search port compares a key against every slot at once and reports the lowest-numbered slot whose stored word equals the key.

Each slot carries a valid flag. Reset clears the flag, and any write to the slot sets it. A slot that has never been written takes no part in a search. Read and search answers are registered and appear one cycle after the request. A write takes effect at the rising edge of the clock. When a read or a search lands in the same cycle as a write to the same slot, it sees the contents from before that write.

The reset input is asserted asynchronously. Its release is synchronised inside the block, so the block leaves reset two rising edges after the input goes high.

Top module: `cam_core`

## Requirements
- R1: After reset every slot is invalid and holds zero, and rd_vld, rd_word, srch_hit and srch_idx are all 0.
- R2: When wr_req is high at a rising edge, wr_data is stored in slot wr_idx and that slot becomes valid.
- R3: A read request returns the word held in slot rd_idx on rd_word, with rd_vld high, in the cycle after the request. rd_vld stays high for that one cycle only.
- R4: In a cycle after one with no read request, rd_vld is 0 and rd_word is 0.
- R5: A slot matches only when it is valid and all 32 stored bits equal srch_key. A key that differs in a single bit does not match.
- R6: When several slots match, srch_idx reports the lowest-numbered one. srch_hit is high in the cycle after the search.
- R7: srch_idx is 0 whenever srch_hit is 0. srch_hit is 0 in the cycle after a search that finds no match, and in the cycle after a cycle with no search.
- R8: Slots that have never been written never match. Searching for the key 0 in an empty array gives srch_hit = 0. After 0 is written to a slot, the same search finds that slot.
- R9: A read or search in the same cycle as a write to the same slot sees the slot's contents from before the write.
- R10: Read, write and search requests in the same cycle are all serviced, each with its own result.
- R11: Overwriting a slot replaces its word. The old word no longer matches in that slot, and a search for it falls through to the next matching slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| rd_req | input | 1 | Read request |
| rd_idx | input | 5 | Slot to read |
| wr_req | input | 1 | Write request |
| wr_idx | input | 5 | Slot to write |
| wr_data | input | 32 | Word to store |
| srch_req | input | 1 | Search request |
| srch_key | input | 32 | Key compared against all slots |
| rd_vld | output | 1 | Read answer present (one cycle) |
| rd_word | output | 32 | Read answer, 0 when no read was requested |
| srch_hit | output | 1 | At least one slot matched the key |
| srch_idx | output | 5 | Lowest matching slot, 0 on a miss |

## Verification
The operations most likely to collide are a write and a search, or a write and a read, aimed at the same slot in the same cycle. The bench provokes this by overwriting a slot that currently holds the only low-numbered copy of a key, while it searches for that key and reads the same slot in the same request. The expected answer is the old word and the old slot index. One cycle later, the same search must fall through to the next duplicate higher up. A randomised phase then mixes all three ports over a small set of keys, so same-cycle collisions and duplicate matches happen often, and a reference model in the scoreboard judges each of them.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned CAM_SLOTS_DEF = 32;
  localparam int unsigned CAM_WIDTH_DEF = 32;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/cam_slot.sv
module cam_slot #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] key,
  output logic [WIDTH-1:0] word_o,
  output logic             vld_o,
  output logic             match_o
);
  logic [WIDTH-1:0] word_q, word_d;
  logic             vld_q, vld_d;

  always_comb begin
    word_d = word_q;
    vld_d  = vld_q;
    if (wr_en) begin
      word_d = wr_data;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (wr_en) begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o  = word_q;
  assign vld_o   = vld_q;
  assign match_o = vld_q & (word_q == key);

  // R2
  slot_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |=> (vld_o && word_o == $past(wr_data)));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_en |=> ($stable(word_o) && $stable(vld_o)));
endmodule

// File: rtl/cam_wr_decode.sv
module cam_wr_decode #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  output logic [SLOTS-1:0] wr_en_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_line
    assign wr_en_o[g] = wr_req & (wr_idx == IDX_W'(g));
  end

  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(wr_en_o));

  // R2
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !wr_req |-> (wr_en_o == '0));
endmodule

// File: rtl/cam_rd_mux.sv
module cam_rd_mux #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0][WIDTH-1:0] words,
  input  logic [IDX_W-1:0]            sel,
  output logic [WIDTH-1:0]            word_o
);
  logic [SLOTS-1:0][WIDTH-1:0] gated;

  for (genvar g = 0; g < SLOTS; g++) begin : g_gate
    assign gated[g] = (sel == IDX_W'(g)) ? words[g] : '0;
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < SLOTS; i++) word_o = word_o | gated[i];
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [SLOTS-1:0] lines,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (lines[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |lines;

  // R6
  enc_points_at_hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    any_o |-> lines[idx_o]);

  // R6
  enc_lowest_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    any_o |-> ((lines & ((SLOTS'(1) << idx_o) - SLOTS'(1))) == '0));
endmodule

// File: rtl/cam_core.sv
module cam_core #(
  parameter int unsigned SLOTS = cam_pkg::CAM_SLOTS_DEF,
  parameter int unsigned WIDTH = cam_pkg::CAM_WIDTH_DEF,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_req,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             srch_req,
  input  logic [WIDTH-1:0] srch_key,
  output logic             rd_vld,
  output logic [WIDTH-1:0] rd_word,
  output logic             srch_hit,
  output logic [IDX_W-1:0] srch_idx
);
  logic                        rst_ns;
  logic [SLOTS-1:0]            wr_en;
  logic [SLOTS-1:0][WIDTH-1:0] words;
  logic [SLOTS-1:0]            vld_vec;
  logic [SLOTS-1:0]            match_vec;
  logic [WIDTH-1:0]            mux_word;
  logic                        enc_any;
  logic [IDX_W-1:0]            enc_idx;

  logic             rd_vld_q, rd_vld_d;
  logic [WIDTH-1:0] rd_word_q, rd_word_d;
  logic             hit_q, hit_d;
  logic [IDX_W-1:0] sidx_q, sidx_d;
  logic             rd_ce, sr_ce;

  cam_rst_sync u_rsync (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  cam_wr_decode #(.SLOTS(SLOTS)) u_dec (
    .clk(clk), .rst_ns(rst_ns), .wr_req(wr_req), .wr_idx(wr_idx), .wr_en_o(wr_en)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    cam_slot #(.WIDTH(WIDTH)) u_slot (
      .clk(clk), .rst_ns(rst_ns), .wr_en(wr_en[g]), .wr_data(wr_data),
      .key(srch_key), .word_o(words[g]), .vld_o(vld_vec[g]), .match_o(match_vec[g])
    );
  end

  cam_rd_mux #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_rmux (
    .words(words), .sel(rd_idx), .word_o(mux_word)
  );

  cam_prio_enc #(.SLOTS(SLOTS)) u_enc (
    .clk(clk), .rst_ns(rst_ns), .lines(match_vec), .any_o(enc_any), .idx_o(enc_idx)
  );

  // next-state for the registered answers
  always_comb begin
    rd_vld_d  = rd_req;
    rd_word_d = rd_req ? mux_word : '0;
    hit_d     = srch_req & enc_any;
    sidx_d    = (srch_req & enc_any) ? enc_idx : '0;
    rd_ce     = rd_req | rd_vld_q;
    sr_ce     = srch_req | hit_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_vld_q  <= 1'b0;
      rd_word_q <= '0;
    end else if (rd_ce) begin
      rd_vld_q  <= rd_vld_d;
      rd_word_q <= rd_word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hit_q  <= 1'b0;
      sidx_q <= '0;
    end else if (sr_ce) begin
      hit_q  <= hit_d;
      sidx_q <= sidx_d;
    end
  end

  assign rd_vld   = rd_vld_q;
  assign rd_word  = rd_word_q;
  assign srch_hit = hit_q;
  assign srch_idx = sidx_q;

  // R3
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_req |=> rd_vld);

  // R4
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !rd_req |=> (!rd_vld && rd_word == '0));

  // R7
  miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !srch_hit |-> (srch_idx == '0));

  // R7
  no_search_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !srch_req |=> !srch_hit);

  // R8
  empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (srch_req && vld_vec == '0) |=> !srch_hit);
endmodule

// File: tb/cam_core_bench.sv
module cam_core_bench;
  localparam int SLOTS = 32;
  localparam int WIDTH = 32;
  localparam int IDX_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rd_req = 1'b0, wr_req = 1'b0, srch_req = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0, wr_idx = '0;
  logic [WIDTH-1:0] wr_data = '0, srch_key = '0;
  logic             rd_vld, srch_hit;
  logic [WIDTH-1:0] rd_word;
  logic [IDX_W-1:0] srch_idx;

  int total = 0;
  int bad = 0;

  // scoreboard: {rd_vld, rd_word, srch_hit, srch_idx}
  logic [WIDTH+IDX_W+1:0] exp_q[$];
  string                  tag_q[$];

  logic [WIDTH-1:0] m_word[SLOTS];
  bit               m_vld[SLOTS];

  always #10 clk = ~clk;

  cam_core u_cam_core (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx(rd_idx),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .srch_req(srch_req), .srch_key(srch_key),
    .rd_vld(rd_vld), .rd_word(rd_word), .srch_hit(srch_hit), .srch_idx(srch_idx)
  );

  task automatic check(string tag, logic [WIDTH+IDX_W+1:0] act, logic [WIDTH+IDX_W+1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, bit rd, int ridx, bit wr, int widx,
                       logic [WIDTH-1:0] wd, bit sr, logic [WIDTH-1:0] key);
    logic             e_hit = 1'b0;
    logic [IDX_W-1:0] e_idx = '0;
    logic [WIDTH-1:0] e_rd;
    @(negedge clk);
    rd_req = rd; rd_idx = IDX_W'(ridx);
    wr_req = wr; wr_idx = IDX_W'(widx); wr_data = wd;
    srch_req = sr; srch_key = key;
    e_rd = rd ? m_word[ridx] : '0;
    if (sr) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (!e_hit && m_vld[i] && m_word[i] == key) begin
          e_hit = 1'b1;
          e_idx = IDX_W'(i);
        end
      end
    end
    if (wr) begin
      m_word[widx] = wd;
      m_vld[widx]  = 1'b1;
    end
    exp_q.push_back({rd, e_rd, e_hit, e_idx});
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    issue(tag, 0, 0, 0, 0, '0, 0, '0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        check(tag_q.pop_front(), {rd_vld, rd_word, srch_hit, srch_idx}, exp_q.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [WIDTH-1:0] KA = 32'hA5A5_0F0F;
  localparam logic [WIDTH-1:0] KB = 32'h1234_5678;
  localparam logic [WIDTH-1:0] KC = 32'hFFFF_FFFF;
  localparam logic [WIDTH-1:0] KD = 32'h0000_0001;
  localparam logic [WIDTH-1:0] KE = 32'hDEAD_BEEF;

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      m_word[i] = '0;
      m_vld[i]  = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs idle after reset
    check("R1 reset outputs", {rd_vld, rd_word, srch_hit, srch_idx}, '0);

    issue("R1 empty slot reads zero", 1, 5, 0, 0, '0, 0, '0);
    issue("R1 empty top slot reads zero", 1, 31, 0, 0, '0, 0, '0);
    issue("R8 search zero in empty array", 0, 0, 0, 0, '0, 1, '0);

    issue("R2 write", 0, 0, 1, 3, KA, 0, '0);
    issue("R2 write", 0, 0, 1, 7, KB, 0, '0);
    issue("R2 write", 0, 0, 1, 20, KA, 0, '0);
    issue("R2 write", 0, 0, 1, 31, KC, 0, '0);
    issue("R2 write", 0, 0, 1, 0, KD, 0, '0);

    issue("R3 read slot 3", 1, 3, 0, 0, '0, 0, '0);
    issue("R3 read slot 31", 1, 31, 0, 0, '0, 0, '0);
    issue("R3 read slot 0", 1, 0, 0, 0, '0, 0, '0);
    issue("R4 no read after read", 0, 0, 0, 0, '0, 0, '0);

    issue("R6 duplicate key lowest slot", 0, 0, 0, 0, '0, 1, KA);
    issue("R5 exact match top slot", 0, 0, 0, 0, '0, 1, KC);
    issue("R5 match slot 0", 0, 0, 0, 0, '0, 1, KD);
    issue("R5 one bit off misses", 0, 0, 0, 0, '0, 1, KA ^ 32'h0000_0100);
    idle("R7 no search after search");

    issue("R8 zero still misses", 0, 0, 0, 0, '0, 1, '0);
    issue("R8 write zero", 0, 0, 1, 10, '0, 0, '0);
    issue("R8 zero now hits", 0, 0, 0, 0, '0, 1, '0);

    // R9: overwrite slot 3 while reading and searching it
    issue("R9 same cycle collision", 1, 3, 1, 3, KE, 1, KA);
    issue("R11 old key falls through", 1, 3, 0, 0, '0, 1, KA);
    issue("R11 new key found", 0, 0, 0, 0, '0, 1, KE);

    // R10: all three ports on different slots
    issue("R10 concurrent ports", 1, 7, 1, 12, KB, 1, KC);
    issue("R10 concurrent ports", 1, 12, 1, 1, KA, 1, KB);
    issue("R10 concurrent ports", 0, 0, 0, 0, '0, 1, KA);

    // R10: randomised mix over a small key set
    for (int n = 0; n < 400; n++) begin
      logic [WIDTH-1:0] ks[5];
      ks[0] = KA; ks[1] = KB; ks[2] = KC; ks[3] = KD; ks[4] = KE;
      issue("R10 random mix",
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)), ks[$urandom_range(0, 4)],
            bit'($urandom_range(0, 1)), ks[$urandom_range(0, 4)]);
    end

    idle("R4 R7 idle tail");
    idle("R4 R7 idle tail");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule